// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two data ports, A and B, and moves data across in either direction. Each direction has a capture register of its own. Each direction also has a select input. The select decides whether the driven port receives the live value from the opposite port or the value captured earlier. Both port pads are modelled as separate input, output and output-enable vectors, so the block can sit in front of tri-state pad cells.

The captures are made in the single system clock domain. Each capture strobe is sampled there, and a register loads on a detected low-to-high transition of its strobe. A capture happens whatever the enable and direction settings are. As a result, the ports can be isolated while data is still being stored. An active-low enable and a direction bit pick which port, if either, is driven. The live path is combinational and adds no cycle of latency. The block is built from identical lanes. Each lane has its own full set of controls, and lanes do not affect one another.

Top module: `dual_reg_xcvr`

## Requirements
- R1: When `ab_stb` of a lane is sampled high at a clock edge after being sampled low at the previous edge, that lane's A-to-B register loads `a_in` of the lane at that edge.
- R2: When `ba_stb` of a lane is sampled high at a clock edge after being sampled low at the previous edge, that lane's B-to-A register loads `b_in` of the lane at that same edge.
- R3: Capture takes place regardless of `en_n` and `dir`, including while the ports are isolated. Both registers of a lane may load at the same edge.
- R4: A register keeps its value at every edge where its strobe has no rising transition, including while the strobe is held high.
- R5: With `en_n` high, the lane drives neither port: all of its `a_oe` and `b_oe` bits are 0, and its `a_out` and `b_out` are 0.
- R6: With `en_n` low, `dir`=0 drives port A (all `a_oe` bits 1, `b_oe` 0), and `dir`=1 drives port B (all `b_oe` bits 1, `a_oe` 0). Both ports are never driven at once.
- R7: When port A is driven, `a_out` equals live `b_in` if `sel_ba`=0, or the B-to-A register if `sel_ba`=1. `sel_ab` has no effect on it. When A is not driven, `a_out` is 0.
- R8: When port B is driven, `b_out` equals live `a_in` if `sel_ab`=0, or the A-to-B register if `sel_ab`=1. `sel_ba` has no effect on it. When B is not driven, `b_out` is 0.
- R9: While `rst_n` is low, no output-enable bit is set. Reset clears both registers of every lane to 0.
- R10: Lane k uses bits [k*LANE_W +: LANE_W] of each data vector and bit k of each control vector. Controls of one lane never change another lane's outputs or registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | LANES | Active-low output enable, per lane |
| dir | input | LANES | Direction: 0 drives A, 1 drives B |
| sel_ab | input | LANES | B-port source: 0 live A, 1 stored A |
| sel_ba | input | LANES | A-port source: 0 live B, 1 stored B |
| ab_stb | input | LANES | Capture strobe for the A-to-B register |
| ba_stb | input | LANES | Capture strobe for the B-to-A register |
| a_in | input | LANES*LANE_W | Value seen on the A pads |
| b_in | input | LANES*LANE_W | Value seen on the B pads |
| a_out | output | LANES*LANE_W | Data driven toward the A pads |
| a_oe | output | LANES*LANE_W | Per-bit output enable of the A pads |
| b_out | output | LANES*LANE_W | Data driven toward the B pads |
| b_oe | output | LANES*LANE_W | Per-bit output enable of the B pads |

## Verification
The routing is tried with a table that covers every combination class of enable, direction and both selects. The live and stored values are chosen to differ in every vector, so a wrong mux leg shows up at once. Vectors that set the unused select show that it is ignored. Capture is tried with a single rising edge, with a strobe held high while the input changes, and with a strobe dropped while the input changes. These cases separate edge detection from level loading. Simultaneous captures made while the ports are isolated, and a strobe pulsed on one lane only, separate shared control from per-lane control. Resets issued at the start and in the middle of the run confirm that the registers clear and that the enables stay low.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drv_e;

  // Which port a lane drives, given reset, enable and direction.
  function automatic drv_e drive_of(input logic rst_n, input logic en_n,
                                    input logic dir);
    if (!rst_n || en_n) return DRV_NONE;
    return dir ? DRV_B : DRV_A;
  endfunction

endpackage

// File: rtl/xcvr_rise.sv
module xcvr_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl && !prev_q;

  // R4
  held_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && $past(lvl)) |-> !rise);
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R1 R2
  load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));

  // R4
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         ab_stb,
  input  logic         ba_stb,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  // Source mux for a driven port; zero when the port is not driven.
  function automatic logic [W-1:0] route(input logic drv, input logic use_reg,
                                         input logic [W-1:0] live,
                                         input logic [W-1:0] stored);
    if (!drv) return '0;
    return use_reg ? stored : live;
  endfunction

  logic         cap_ab, cap_ba;
  logic [W-1:0] q_ab, q_ba;
  drv_e         drv;
  logic         a_drv, b_drv;

  xcvr_rise u_rise_ab (.clk(clk), .rst_n(rst_n), .lvl(ab_stb), .rise(cap_ab));
  xcvr_rise u_rise_ba (.clk(clk), .rst_n(rst_n), .lvl(ba_stb), .rise(cap_ba));

  xcvr_store #(.W(W)) u_reg_ab (.clk(clk), .rst_n(rst_n), .load(cap_ab),
                                .d(a_in), .q(q_ab));
  xcvr_store #(.W(W)) u_reg_ba (.clk(clk), .rst_n(rst_n), .load(cap_ba),
                                .d(b_in), .q(q_ba));

  assign drv   = drive_of(rst_n, en_n, dir);
  assign a_drv = (drv == DRV_A);
  assign b_drv = (drv == DRV_B);

  assign a_oe  = {W{a_drv}};
  assign b_oe  = {W{b_drv}};
  assign a_out = route(a_drv, sel_ba, b_in, q_ba);
  assign b_out = route(b_drv, sel_ab, a_in, q_ab);

  // R6
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)));

  // R5
  isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (a_oe == '0 && b_oe == '0));

  // R7
  a_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !dir && sel_ba) |-> (a_out == q_ba));

  // R8
  b_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && dir && sel_ab) |-> (b_out == q_ab));

  // R3
  cap_any_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && cap_ab) |=> (q_ab == $past(a_in)));
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        en_n,
  input  logic [LANES-1:0]        dir,
  input  logic [LANES-1:0]        sel_ab,
  input  logic [LANES-1:0]        sel_ba,
  input  logic [LANES-1:0]        ab_stb,
  input  logic [LANES-1:0]        ba_stb,
  input  logic [LANES*LANE_W-1:0] a_in,
  input  logic [LANES*LANE_W-1:0] b_in,
  output logic [LANES*LANE_W-1:0] a_out,
  output logic [LANES*LANE_W-1:0] a_oe,
  output logic [LANES*LANE_W-1:0] b_out,
  output logic [LANES*LANE_W-1:0] b_oe
);
  localparam int BUS_W = LANES * LANE_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    xcvr_lane #(.W(LANE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_n   (en_n[k]),
      .dir    (dir[k]),
      .sel_ab (sel_ab[k]),
      .sel_ba (sel_ba[k]),
      .ab_stb (ab_stb[k]),
      .ba_stb (ba_stb[k]),
      .a_in   (a_in[k*LANE_W +: LANE_W]),
      .b_in   (b_in[k*LANE_W +: LANE_W]),
      .a_out  (a_out[k*LANE_W +: LANE_W]),
      .a_oe   (a_oe[k*LANE_W +: LANE_W]),
      .b_out  (b_out[k*LANE_W +: LANE_W]),
      .b_oe   (b_oe[k*LANE_W +: LANE_W])
    );
  end

  // R6
  bus_one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_oe & b_oe) == {BUS_W{1'b0}}));
endmodule

// File: tb/tb_dual_reg_xcvr.sv
module tb_dual_reg_xcvr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  en_n, dir, sel_ab, sel_ba, ab_stb, ba_stb;
  logic [15:0] a_in, b_in, a_out, a_oe, b_out, b_oe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_reg_xcvr dut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir(dir), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .ab_stb(ab_stb), .ba_stb(ba_stb), .a_in(a_in),
    .b_in(b_in), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  // Lane 0 vectors: {en_n, dir, sel_ab, sel_ba, a_in, b_in, exp a_oe,
  // exp b_oe, exp a_out, exp b_out}. Stored A = 5A, stored B = A5.
  localparam logic [51:0] VECS [0:7] = '{
    {4'b1000, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 8'h00},  // R5
    {4'b1111, 8'h33, 8'h44, 8'h00, 8'h00, 8'h00, 8'h00},  // R5
    {4'b0000, 8'h12, 8'h34, 8'hFF, 8'h00, 8'h34, 8'h00},  // R6 R7 live
    {4'b0001, 8'h12, 8'h34, 8'hFF, 8'h00, 8'hA5, 8'h00},  // R7 stored
    {4'b0100, 8'h56, 8'h78, 8'h00, 8'hFF, 8'h00, 8'h56},  // R6 R8 live
    {4'b0110, 8'h56, 8'h78, 8'h00, 8'hFF, 8'h00, 8'h5A},  // R8 stored
    {4'b0010, 8'h9A, 8'hBC, 8'hFF, 8'h00, 8'hBC, 8'h00},  // R7 sel_ab ignored
    {4'b0101, 8'hDE, 8'hF0, 8'h00, 8'hFF, 8'h00, 8'hDE}   // R8 sel_ba ignored
  };

  task automatic chk(input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // Read stored registers of a lane through the normal ports.
  task automatic read_ab(input int k, output logic [7:0] v);
    en_n[k] = 1'b0; dir[k] = 1'b1; sel_ab[k] = 1'b1; #1;
    v = b_out[k*8 +: 8];
    en_n[k] = 1'b1; #1;
  endtask

  task automatic read_ba(input int k, output logic [7:0] v);
    en_n[k] = 1'b0; dir[k] = 1'b0; sel_ba[k] = 1'b1; #1;
    v = a_out[k*8 +: 8];
    en_n[k] = 1'b1; #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    rst_n = 1'b0; en_n = 2'b00; dir = 2'b00; sel_ab = 2'b00; sel_ba = 2'b00;
    ab_stb = 2'b00; ba_stb = 2'b00; a_in = 16'h0; b_in = 16'h0;
    tick(); #1;
    chk("R9 oe in reset", a_oe | b_oe, 16'h0000);
    tick();
    rst_n = 1'b1; en_n = 2'b11;
    tick();
    read_ab(0, v); chk("R9 A reg cleared", {8'h0, v}, 16'h0000);
    read_ba(1, v); chk("R9 B reg cleared", {8'h0, v}, 16'h0000);

    // R1 R2 R3: simultaneous captures on both lanes while isolated
    a_in = 16'hC35A; b_in = 16'h3CA5; ab_stb = 2'b11; ba_stb = 2'b11;
    tick();
    read_ab(0, v); chk("R1 lane0 A capture", {8'h0, v}, 16'h005A);
    read_ab(1, v); chk("R1 lane1 A capture", {8'h0, v}, 16'h00C3);
    read_ba(0, v); chk("R2 R3 lane0 B capture", {8'h0, v}, 16'h00A5);
    read_ba(1, v); chk("R2 R3 lane1 B capture", {8'h0, v}, 16'h003C);

    // R4: strobe held high, input changes, no reload
    a_in = 16'h7777; b_in = 16'h8888;
    tick(); tick();
    read_ab(0, v); chk("R4 held strobe A", {8'h0, v}, 16'h005A);
    read_ba(0, v); chk("R4 held strobe B", {8'h0, v}, 16'h00A5);
    ab_stb = 2'b00; ba_stb = 2'b00; a_in = 16'h6666; b_in = 16'h9999;
    tick(); tick();
    read_ab(0, v); chk("R4 falling strobe", {8'h0, v}, 16'h005A);

    // R10: pulse lane1 strobe only
    a_in = 16'hE1E2; ab_stb = 2'b10;
    tick(); ab_stb = 2'b00; tick();
    read_ab(1, v); chk("R10 lane1 loads", {8'h0, v}, 16'h00E1);
    read_ab(0, v); chk("R10 lane0 untouched", {8'h0, v}, 16'h005A);

    // Table walk on lane 0; lane 1 stays isolated
    en_n = 2'b11; sel_ab = 2'b00; sel_ba = 2'b00; dir = 2'b00;
    for (int i = 0; i < 8; i++) begin
      logic [51:0] e;
      e = VECS[i];
      {en_n[0], dir[0], sel_ab[0], sel_ba[0]} = e[51:48];
      a_in = {8'hFF, e[47:40]}; b_in = {8'hFF, e[39:32]};
      tick(); #1;
      chk($sformatf("R5 R6 a_oe vec%0d", i), a_oe, {8'h00, e[31:24]});
      chk($sformatf("R6 b_oe vec%0d", i), b_oe, {8'h00, e[23:16]});
      chk($sformatf("R7 a_out vec%0d", i), a_out, {8'h00, e[15:8]});
      chk($sformatf("R8 b_out vec%0d", i), b_out, {8'h00, e[7:0]});
    end

    // R9: mid-run reset clears registers
    en_n = 2'b11;
    rst_n = 1'b0; #1;
    en_n = 2'b00; #1;
    chk("R9 oe low in mid reset", a_oe | b_oe, 16'h0000);
    en_n = 2'b11;
    tick(); rst_n = 1'b1; tick();
    read_ab(0, v); chk("R9 A reg after reset", {8'h0, v}, 16'h0000);
    read_ba(0, v); chk("R9 B reg after reset", {8'h0, v}, 16'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule